// File: doc/BRIEF.md
# DMA Channel Transfer Address and Count Engine

This block sequences the transfers of a single DMA channel. A register file loads a 16-bit base offset, a 16-bit base count (stored as the number of transfers minus one), an 8-bit page value, a mode byte and a width select. Each time the channel is serviced, the engine presents one transfer. The transfer carries a 24-bit physical address, a direction and a last-transfer flag. The engine then advances its current offset and count.

The offset runs inside a fixed page and never carries into the page bits. In byte width a page spans 64 KiB. In word width the offset is shifted left by one, page bit 0 is dropped and a page spans 128 KiB. At terminal count the channel either masks itself or, when auto-initialize is selected, reloads its current registers from the base registers. A cascade mode turns the channel into a plain request-to-acknowledge pass-through. The remaining byte count is always visible, so software can read the residue of an interrupted transfer.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is masked, `tc_seen` is 0, `xfer_valid` and `dack` are 0, and `residue_bytes` reads 1.
- R2: A `cfg_load` pulse copies offset and count into both base and current registers and latches page, mode and width. It clears `tc_seen` and leaves the mask unchanged. A `unmask_req` pulse clears the mask.
- R3: In byte width (`cfg_wide`=0) the transfer address is {page[7:0], offset[15:0]}.
- R4: In word width (`cfg_wide`=1) the transfer address is {page[7:1], offset[15:0], 0}. Page bit 0 has no effect and bit 0 of the address is always 0.
- R5: Each transfer adds one to the offset. 0xFFFF wraps to 0x0000 and the page bits stay unchanged.
- R6: A count of N gives N+1 transfers. `xfer_last` is 1 on the transfer issued while the current count is 0x0000, and that transfer leaves the count at 0xFFFF.
- R7: At terminal count with auto-initialize off, the channel sets `tc_seen` and masks itself. A masked channel ignores `dreq` and issues no transfer.
- R8: At terminal count with auto-initialize on (mode bit 4 = 1), the current offset and count reload from the base values. The channel stays unmasked and `tc_seen` is set.
- R9: Single service: a request seen while idle and unmasked gives `xfer_valid` with `dack` in the next cycle. Two cycles without a transfer follow each transfer, so a held request gives one transfer every three cycles.
- R10: Mode bits [3:2] = 01 (for example 0x44) give `xfer_to_mem`=1, which is I/O to memory. Bits [3:2] = 10 (for example 0x48) give `xfer_to_mem`=0.
- R11: Mode bits [7:6] = 11 (for example 0xC0) select cascade. `dack` then follows `dreq` in the same cycle while the channel is unmasked. No transfer is issued and the offset and count do not move.
- R12: `residue_bytes` equals (count+1) mod 65536 in byte width and twice that value in word width.
- R13: A `cfg_load` in the same cycle as a transfer takes priority. The transfer does not advance or reload the registers, and the loaded values stand.
- R14: A terminal count that masks the channel takes priority over a `unmask_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load base/current registers, page, mode, width |
| cfg_base_addr | input | 16 | Starting offset within the page |
| cfg_base_cnt | input | 16 | Transfers minus one |
| cfg_page | input | 8 | Page value |
| cfg_mode | input | 8 | Mode byte (kind [7:6], auto-init [4], direction [3:2]) |
| cfg_wide | input | 1 | 1 = word width, 0 = byte width |
| unmask_req | input | 1 | Clear the channel mask |
| dreq | input | 1 | Service request |
| dack | output | 1 | Service acknowledge |
| xfer_valid | output | 1 | A transfer is presented this cycle |
| xfer_addr | output | 24 | Physical byte address of the transfer |
| xfer_to_mem | output | 1 | 1 = I/O to memory, 0 = memory to I/O |
| xfer_last | output | 1 | Terminal-count transfer |
| chan_masked | output | 1 | Channel mask state |
| tc_seen | output | 1 | Sticky terminal-count status |
| residue_bytes | output | 17 | Bytes still to transfer |

## Verification
Two pairs of events can land on the same clock edge. In the first, a register load arrives on the cycle a transfer is presented. The bench waits for `xfer_valid` and raises `cfg_load` in that cycle. It then judges the result by the residue and by the address of the next transfer, which must be the newly loaded offset without any increment. In the second, the mask-clear request coincides with a terminal-count transfer. The bench raises `unmask_req` in the terminal-count cycle and expects the channel to end up masked. A behavioural model run alongside compares every output on every clock.

// File: rtl/dma_eng_pkg.sv
// Package: shared types and mode-field decoding for the DMA channel engine.
// Assumes the mode byte layout: kind [7:6], auto-init [4], direction [3:2].
package dma_eng_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_GAP  = 2'd2
    } svc_phase_t;

    typedef struct packed {
        logic [1:0] kind;
        logic       autoinit;
        logic [1:0] dir;
    } chan_mode_t;

    localparam logic [1:0] KIND_CASCADE = 2'b11;
    localparam logic [1:0] DIR_TO_MEM   = 2'b01;

    // Extract the fields the engine acts on from a raw mode byte.
    function automatic chan_mode_t decode_mode(input logic [7:0] raw);
        chan_mode_t m;
        m.kind     = raw[7:6];
        m.autoinit = raw[4];
        m.dir      = raw[3:2];
        return m;
    endfunction

endpackage

// File: rtl/dma_ctr_regs.sv
// Module: base and current offset/count registers of one channel.
// Assumes load has priority over step; step advances or, at the last
// transfer with reload set, copies the base values back into current.
module dma_ctr_regs #(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFS_W-1:0] base_addr_in,
    input  logic [OFS_W-1:0] base_cnt_in,
    input  logic             step,
    input  logic             reload,
    output logic [OFS_W-1:0] cur_addr,
    output logic [OFS_W-1:0] cur_cnt,
    output logic             at_last,
    output logic [OFS_W-1:0] residue_xfers
);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    logic [OFS_W-1:0] base_addr_q;
    logic [OFS_W-1:0] base_cnt_q;

    assign at_last       = (cur_cnt == '0);
    assign residue_xfers = cur_cnt + ONE;

    // Base registers: written only by a configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
        end else if (load) begin
            base_addr_q <= base_addr_in;
            base_cnt_q  <= base_cnt_in;
        end
    end

    // Current registers: load, auto-init reload, or advance by one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (load) begin
            cur_addr <= base_addr_in;
            cur_cnt  <= base_cnt_in;
        end else if (step) begin
            if (at_last && reload) begin
                cur_addr <= base_addr_q;
                cur_cnt  <= base_cnt_q;
            end else begin
                cur_addr <= cur_addr + ONE;
                cur_cnt  <= cur_cnt - ONE;
            end
        end
    end

endmodule

// File: rtl/dma_addr_form.sv
// Module: forms the physical byte address from page and offset.
// Assumes PAGE_W >= 2; word width drops page bit 0 and shifts the offset.
module dma_addr_form #(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic                    wide,
    input  logic [PAGE_W-1:0]       page,
    input  logic [OFS_W-1:0]        offset,
    output logic [PAGE_W+OFS_W-1:0] phys
);
    localparam int ADDR_W = PAGE_W + OFS_W;

    logic [ADDR_W-1:0] byte_form;
    logic [ADDR_W-1:0] word_form;
    logic              page_lsb_unused;

    assign byte_form = {page, offset};

    generate
        if (PAGE_W > 1) begin : g_word_page
            assign word_form = {page[PAGE_W-1:1], offset, 1'b0};
        end else begin : g_word_nopage
            assign word_form = {offset, 1'b0};
        end
    endgenerate

    assign page_lsb_unused = page[0];

    // Pick the address layout for the latched width.
    always_comb begin
        phys = wide ? word_form : byte_form;
    end

endmodule

// File: rtl/dma_service_fsm.sv
// Module: single-service sequencer, channel mask and terminal-count status.
// Assumes one transfer per service followed by a release cycle; load
// suppresses the register update of a coinciding transfer.
module dma_service_fsm
    import dma_eng_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic cascade,
    input  logic autoinit,
    input  logic load,
    input  logic unmask_req,
    input  logic at_last,
    output logic xfer_valid,
    output logic step,
    output logic dack,
    output logic masked,
    output logic tc_seen
);
    svc_phase_t phase_q;
    svc_phase_t phase_d;
    logic       tc_hit;

    assign xfer_valid = (phase_q == PH_XFER);
    assign step       = xfer_valid && !load;
    assign tc_hit     = step && at_last;
    assign dack       = xfer_valid || (cascade && dreq && !masked);

    // Next service phase: idle -> transfer -> release gap -> idle.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (dreq && !masked && !cascade) phase_d = PH_XFER;
            PH_XFER: phase_d = PH_GAP;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Mask: set by non-auto-init terminal count, which beats an unmask request.
    always_ff @(posedge clk) begin
        if (!rst_n)                   masked <= 1'b1;
        else if (tc_hit && !autoinit) masked <= 1'b1;
        else if (unmask_req)          masked <= 1'b0;
    end

    // Sticky terminal-count status, cleared by a configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n)      tc_seen <= 1'b0;
        else if (load)   tc_seen <= 1'b0;
        else if (tc_hit) tc_seen <= 1'b1;
    end

endmodule

// File: rtl/dma_chan_engine.sv
// Module: top of one DMA channel's address and count engine.
// Assumes configuration is written only while the channel is idle or,
// if it coincides with a transfer, that the load is meant to win.
module dma_chan_engine
    import dma_eng_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8,
    parameter int MODE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic [OFS_W-1:0]        cfg_base_addr,
    input  logic [OFS_W-1:0]        cfg_base_cnt,
    input  logic [PAGE_W-1:0]       cfg_page,
    input  logic [MODE_W-1:0]       cfg_mode,
    input  logic                    cfg_wide,
    input  logic                    unmask_req,
    input  logic                    dreq,
    output logic                    dack,
    output logic                    xfer_valid,
    output logic [PAGE_W+OFS_W-1:0] xfer_addr,
    output logic                    xfer_to_mem,
    output logic                    xfer_last,
    output logic                    chan_masked,
    output logic                    tc_seen,
    output logic [OFS_W:0]          residue_bytes
);
    localparam int ADDR_W = PAGE_W + OFS_W;

    chan_mode_t        mode_q;
    logic [PAGE_W-1:0] page_q;
    logic              wide_q;
    logic              auto_en;
    logic              cascade;
    logic              step;
    logic              at_last;
    logic [OFS_W-1:0]  cur_addr;
    logic [OFS_W-1:0]  cur_cnt;
    logic [OFS_W-1:0]  res_x;
    logic [ADDR_W-1:0] phys;
    logic              mode_rest_unused;

    assign mode_rest_unused = ^{cfg_mode[5], cfg_mode[1:0]};
    assign auto_en = mode_q.autoinit;
    assign cascade = (mode_q.kind == KIND_CASCADE);

    // Latch page, mode fields and width on a configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            page_q <= '0;
            wide_q <= 1'b0;
        end else if (cfg_load) begin
            mode_q <= decode_mode(cfg_mode[7:0]);
            page_q <= cfg_page;
            wide_q <= cfg_wide;
        end
    end

    dma_ctr_regs #(.OFS_W(OFS_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (cfg_load),
        .base_addr_in (cfg_base_addr),
        .base_cnt_in  (cfg_base_cnt),
        .step         (step),
        .reload       (auto_en),
        .cur_addr     (cur_addr),
        .cur_cnt      (cur_cnt),
        .at_last      (at_last),
        .residue_xfers(res_x)
    );

    dma_addr_form #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_addr (
        .wide  (wide_q),
        .page  (page_q),
        .offset(cur_addr),
        .phys  (phys)
    );

    dma_service_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq      (dreq),
        .cascade   (cascade),
        .autoinit  (auto_en),
        .load      (cfg_load),
        .unmask_req(unmask_req),
        .at_last   (at_last),
        .xfer_valid(xfer_valid),
        .step      (step),
        .dack      (dack),
        .masked    (chan_masked),
        .tc_seen   (tc_seen)
    );

    assign xfer_addr     = phys;
    assign xfer_to_mem   = (mode_q.dir == DIR_TO_MEM);
    assign xfer_last     = xfer_valid && at_last;
    assign residue_bytes = wide_q ? {res_x, 1'b0} : {1'b0, res_x};

endmodule

// File: rtl/dma_eng_checker.sv
// Module: temporal checks on the channel engine, attached by bind.
// Assumes it sees the top's ports plus the latched width and auto-init bit.
module dma_eng_checker #(
    parameter int ADDR_W = 24,
    parameter int RES_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic              xfer_valid,
    input logic              xfer_last,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              dack,
    input logic              chan_masked,
    input logic              tc_seen,
    input logic [RES_W-1:0]  residue_bytes,
    input logic              wide_q,
    input logic              auto_en
);
    AST_XFER_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid); // R9

    AST_XFER_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> dack); // R9

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && wide_q) |-> !xfer_addr[0]); // R4

    AST_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_last && !auto_en && !cfg_load) |=> chan_masked); // R7

    AST_TC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_last && !cfg_load) |=> tc_seen); // R7

    AST_RESIDUE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_last && !auto_en && !cfg_load) |=> (residue_bytes == '0)); // R12

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !tc_seen); // R2

endmodule

bind dma_chan_engine dma_eng_checker #(
    .ADDR_W(PAGE_W + OFS_W),
    .RES_W (OFS_W + 1)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .xfer_valid   (xfer_valid),
    .xfer_last    (xfer_last),
    .xfer_addr    (xfer_addr),
    .dack         (dack),
    .chan_masked  (chan_masked),
    .tc_seen      (tc_seen),
    .residue_bytes(residue_bytes),
    .wide_q       (wide_q),
    .auto_en      (auto_en)
);

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
    localparam int CLK_P = 10;
    localparam int Q     = CLK_P / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_base_addr = '0;
    logic [15:0] cfg_base_cnt = '0;
    logic [7:0]  cfg_page = '0;
    logic [7:0]  cfg_mode = '0;
    logic        cfg_wide = 1'b0;
    logic        unmask_req = 1'b0;
    logic        dreq = 1'b0;
    logic        dack, xfer_valid, xfer_to_mem, xfer_last, chan_masked, tc_seen;
    logic [23:0] xfer_addr;
    logic [16:0] residue_bytes;

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] addr_q[$];

    always #(CLK_P/2) clk = ~clk;

    dma_chan_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_base_addr(cfg_base_addr), .cfg_base_cnt(cfg_base_cnt),
        .cfg_page(cfg_page), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
        .unmask_req(unmask_req), .dreq(dreq), .dack(dack),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
        .xfer_to_mem(xfer_to_mem), .xfer_last(xfer_last),
        .chan_masked(chan_masked), .tc_seen(tc_seen),
        .residue_bytes(residue_bytes)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [15:0] m_base_a = '0, m_base_c = '0, m_addr = '0, m_cnt = '0;
    logic [7:0]  m_page = '0, m_mode = '0;
    logic        m_wide = 1'b0, m_mask = 1'b1, m_tcs = 1'b0;
    int          m_ph = 0;

    always @(posedge clk) begin
        logic xf, tc_upd, auto_on;
        xf = (m_ph == 1);
        auto_on = m_mode[4];
        tc_upd = xf && !cfg_load && (m_cnt == 16'h0000);
        if (!rst_n) begin
            m_base_a = '0; m_base_c = '0; m_addr = '0; m_cnt = '0;
            m_page = '0; m_mode = '0; m_wide = 1'b0; m_mask = 1'b1;
            m_tcs = 1'b0; m_ph = 0;
        end else begin
            if (tc_upd && !auto_on) m_mask = 1'b1;
            else if (unmask_req)    m_mask = 1'b0;
            case (m_ph)
                0: if (dreq && !(m_mask_prev_hold()) && (m_mode[7:6] != 2'b11)) m_ph = 1;
                1: m_ph = 2;
                default: m_ph = 0;
            endcase
            if (cfg_load) begin
                m_base_a = cfg_base_addr; m_base_c = cfg_base_cnt;
                m_addr = cfg_base_addr; m_cnt = cfg_base_cnt;
                m_page = cfg_page; m_mode = cfg_mode; m_wide = cfg_wide;
                m_tcs = 1'b0;
            end else if (xf) begin
                if (tc_upd) m_tcs = 1'b1;
                if (tc_upd && auto_on) begin
                    m_addr = m_base_a; m_cnt = m_base_c;
                end else begin
                    m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
                end
            end
        end
        m_mask_old = m_mask;
    end

    // Mask value before this edge's update, used by the idle decision.
    logic m_mask_old = 1'b1;
    logic m_mask_before = 1'b1;
    always @(negedge clk) m_mask_before = m_mask;
    function automatic logic m_mask_prev_hold();
        return m_mask_before;
    endfunction

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        #Q;
        if (rst_n) begin
            logic        e_xf, e_dack;
            logic [15:0] t;
            logic [16:0] e_res;
            logic [23:0] e_addr;
            e_xf   = (m_ph == 1);
            e_dack = e_xf || ((m_mode[7:6] == 2'b11) && dreq && !m_mask);
            t      = m_cnt + 16'd1;
            e_res  = m_wide ? {t, 1'b0} : {1'b0, t};
            e_addr = m_wide ? {m_page[7:1], m_addr, 1'b0} : {m_page, m_addr};
            chk("R9 xfer_valid", 32'(xfer_valid), 32'(e_xf));
            chk("R11 dack", 32'(dack), 32'(e_dack));
            chk("R7 chan_masked", 32'(chan_masked), 32'(m_mask));
            chk("R7 tc_seen", 32'(tc_seen), 32'(m_tcs));
            chk("R12 residue", 32'(residue_bytes), 32'(e_res));
            chk("R6 xfer_last", 32'(xfer_last), 32'(e_xf && (m_cnt == 16'h0)));
            if (e_xf) begin
                chk(m_wide ? "R4 xfer_addr" : "R3 xfer_addr", 32'(xfer_addr), 32'(e_addr));
                chk("R10 xfer_to_mem", 32'(xfer_to_mem), 32'(m_mode[3:2] == 2'b01));
            end
        end
        if (xfer_valid) addr_q.push_back(xfer_addr);
    end

    task automatic do_load(input logic [15:0] a, input logic [15:0] c,
                           input logic [7:0] p, input logic [7:0] m, input logic w);
        @(negedge clk);
        cfg_base_addr = a; cfg_base_cnt = c; cfg_page = p; cfg_mode = m;
        cfg_wide = w; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic do_unmask();
        @(negedge clk);
        unmask_req = 1'b1;
        @(negedge clk);
        unmask_req = 1'b0;
    endtask

    task automatic hold_req(input int n);
        dreq = 1'b1;
        repeat (n) @(negedge clk);
        dreq = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_xfer();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (xfer_valid) break;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #Q;
        chk("R1 masked", 32'(chan_masked), 32'd1);
        chk("R1 tc_seen", 32'(tc_seen), 32'd0);
        chk("R1 xfer_valid", 32'(xfer_valid), 32'd0);
        chk("R1 residue", 32'(residue_bytes), 32'd1);

        // Byte width, offset wrap, four transfers ending in terminal count
        do_load(16'hFFFE, 16'd3, 8'h12, 8'h44, 1'b0);
        do_unmask();
        addr_q.delete();
        hold_req(20);
        chk("R6 transfer count", 32'(addr_q.size()), 32'd4);
        chk("R3 first address", 32'(addr_q[0]), 32'h12FFFE);
        chk("R5 wrap address", 32'(addr_q[2]), 32'h120000);
        chk("R7 masked after tc", 32'(chan_masked), 32'd1);
        chk("R12 residue after tc", 32'(residue_bytes), 32'd0);

        // Word width, page bit 0 ignored
        do_load(16'hFFFF, 16'd1, 8'h35, 8'h48, 1'b1);
        #Q;
        chk("R2 load clears tc_seen", 32'(tc_seen), 32'd0);
        chk("R2 load keeps mask", 32'(chan_masked), 32'd1);
        chk("R12 word residue", 32'(residue_bytes), 32'd4);
        do_unmask();
        addr_q.delete();
        hold_req(15);
        chk("R4 word address", 32'(addr_q[0]), 32'h35FFFE);
        chk("R4 word wrap", 32'(addr_q[1]), 32'h340000);
        chk("R10 memory to I/O", 32'(xfer_to_mem), 32'd0);

        // Auto-initialize
        do_load(16'h0100, 16'd1, 8'h01, 8'h54, 1'b0);
        do_unmask();
        addr_q.delete();
        hold_req(20);
        chk("R8 reload address", 32'(addr_q[2]), 32'h010100);
        chk("R8 stays unmasked", 32'(chan_masked), 32'd0);
        chk("R8 tc_seen", 32'(tc_seen), 32'd1);

        // Cascade pass-through
        do_load(16'h2000, 16'd5, 8'h00, 8'hC0, 1'b0);
        do_unmask();
        addr_q.delete();
        @(negedge clk);
        dreq = 1'b1;
        #Q;
        chk("R11 dack follows dreq", 32'(dack), 32'd1);
        repeat (6) @(negedge clk);
        dreq = 1'b0;
        #Q;
        chk("R11 dack drops", 32'(dack), 32'd0);
        chk("R11 no transfers", 32'(addr_q.size()), 32'd0);
        chk("R11 count unchanged", 32'(residue_bytes), 32'd6);

        // Load coinciding with a transfer
        do_load(16'h0040, 16'd9, 8'h02, 8'h44, 1'b0);
        dreq = 1'b1;
        wait_xfer();
        cfg_base_addr = 16'h0800; cfg_base_cnt = 16'd2; cfg_page = 8'h03;
        cfg_mode = 8'h48; cfg_wide = 1'b0; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        addr_q.delete();
        #Q;
        chk("R13 residue after load", 32'(residue_bytes), 32'd3);
        repeat (4) @(negedge clk);
        dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 next address", 32'(addr_q[0]), 32'h030800);

        // Terminal count beats unmask
        do_load(16'h0000, 16'd0, 8'h04, 8'h44, 1'b0);
        dreq = 1'b1;
        wait_xfer();
        unmask_req = 1'b1;
        @(negedge clk);
        unmask_req = 1'b0;
        dreq = 1'b0;
        #Q;
        chk("R14 masked wins", 32'(chan_masked), 32'd1);

        // Masked channel ignores requests
        addr_q.delete();
        hold_req(10);
        chk("R7 masked ignores dreq", 32'(addr_q.size()), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule